// File: doc/BRIEF.md
# Reloading Interval Timer with Periodic Interrupt

This block is a 16-bit down-counting interval timer with a separate 16-bit reload value. A clock-enable input sets the counting rate, so any prescaling is done outside the block. The count, the reload value and a control byte are reached as byte registers over a simple one-cycle register bus. When the top two bits of the control byte select continuous operation, each expiry of the count produces a one-cycle interrupt-set pulse and raises a sticky interrupt flag. The flag clears when software reads either byte of the count.

Writing one byte of the count replaces just that byte of the live value, and timing restarts from the merged result. When the count passes zero it reloads from the reload register, so later expiries arrive every (reload + 1) ticks. A parameter adds a second, free-running 16-bit counter that has no interrupt and wraps from zero to all ones.

Top module: `lat_timer`

## Requirements
- R1: After reset the count and the reload value are both 0xFFFF, the control byte is 0x00, and t1_flag and t1_set are low. Once continuous mode is selected, the first expiry therefore falls on the 65536th tick.
- R2: A bus write to address 4 replaces only count bits 7:0, and a write to address 5 replaces only bits 15:8. The merged value appears after that clock edge. A count write in the same cycle as a tick takes priority, and no decrement happens in that cycle.
- R3: Each cycle with tick_en high decrements a nonzero count by one. A tick with the count at zero loads the reload value, so after a start value c and reload value L, expiries fall on ticks c, c+L+1, c+2(L+1), and so on (ticks numbered from 0).
- R4: When control bits 7:6 equal 01, every expiring tick gives t1_set high for exactly the cycle after that clock edge and sets t1_flag.
- R5: With control bits 7:6 at any other value (00, 10, 11), expiries raise neither t1_set nor t1_flag, and the count keeps running and reloading. A write to the control byte at address 11 governs the very next tick.
- R6: Writes to address 6 replace reload bits 7:0 and writes to address 7 replace bits 15:8. The other byte is unchanged, and the next reload uses the new value.
- R7: Reads are registered. bus_rdata shows the addressed byte in the cycle after bus_rd and holds its value when no read is made. A count read gives the value from before any tick on that same edge, and it does not disturb the count.
- R8: A read of address 4 or 5 clears t1_flag. If an expiry sets the flag on the same edge, the set wins.
- R9: With HAS_T2 set, addresses 8 and 9 are the low and high bytes of a second counter. Writes to them merge byte-wise. It decrements once per tick, wraps from 0 to 0xFFFF, and never affects t1_set or t1_flag.
- R10: The control byte reads back at address 11. Every address other than 4 to 9 and 11 reads as 0x00, and writes to those addresses leave the count, the reload value and the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Count enable; one tick per cycle in which it is high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd |
| t1_set | output | 1 | One-cycle pulse on an expiry in continuous mode |
| t1_flag | output | 1 | Sticky interrupt flag, cleared by count reads |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. A register write shows up in a readback issued in the next cycle. The t1_set pulse and the rise of t1_flag appear after the edge that applies the expiring tick, and bus_rdata carries the byte captured on the edge where bus_rd was sampled. The bench drives every strobe and tick on the falling edge and samples one falling edge later, so each comparison reads the value due for that single edge. It sweeps small start and reload values, where the expiry tick numbers and the resulting count follow from closed-form arithmetic, and it also runs the full 65536-tick period from reset.

// File: rtl/lt_pkg.sv
`timescale 1ns/1ps
package lt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd4;
  localparam logic [ADDR_W-1:0] A_LAT_LO = 4'd6;
  localparam logic [ADDR_W-1:0] A_T2_LO  = 4'd8;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd11;
  localparam logic [1:0]        MODE_CONT = 2'b01;
endpackage

// File: rtl/lt_rst_sync.sv
`timescale 1ns/1ps
module lt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lt_regdec.sv
`timescale 1ns/1ps
module lt_regdec
  import lt_pkg::*;
#(
  parameter int NB = 2
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NB-1:0]     cnt_wr,
  output logic [NB-1:0]     lat_wr,
  output logic [NB-1:0]     t2_wr,
  output logic              ctrl_wr,
  output logic              cnt_rd
);
  logic [NB-1:0] cnt_hit;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign cnt_hit[i] = (bus_addr == ADDR_W'(int'(A_CNT_LO) + i));
    assign cnt_wr[i]  = bus_wr && cnt_hit[i];
    assign lat_wr[i]  = bus_wr && (bus_addr == ADDR_W'(int'(A_LAT_LO) + i));
    assign t2_wr[i]   = bus_wr && (bus_addr == ADDR_W'(int'(A_T2_LO) + i));
  end

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign cnt_rd  = bus_rd && (|cnt_hit);
endmodule

// File: rtl/lt_counter.sv
`timescale 1ns/1ps
module lt_counter
  import lt_pkg::*;
#(
  parameter int TW = 16,
  localparam int NB = TW / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NB-1:0]     ld,
  input  logic [BYTE_W-1:0] ld_byte,
  input  logic [TW-1:0]     reload_val,
  output logic [TW-1:0]     count,
  output logic              expire
);
  logic [TW-1:0] cnt_q, cnt_d, merged;
  logic          any_ld, at_zero;

  assign any_ld  = |ld;
  assign at_zero = (cnt_q == '0);

  always_comb begin
    merged = cnt_q;
    for (int i = 0; i < NB; i++) begin
      if (ld[i]) merged[i*BYTE_W +: BYTE_W] = ld_byte;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (any_ld)       cnt_d = merged;
    else if (tick)    cnt_d = at_zero ? reload_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign count  = cnt_q;
  assign expire = tick && !any_ld && at_zero;

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !any_ld && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !any_ld && cnt_q == '0) |=> (cnt_q == $past(reload_val)));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !any_ld) |=> $stable(cnt_q));

  for (genvar i = 0; i < NB; i++) begin : g_ldchk
    // R2
    lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld[i] |=> (cnt_q[i*BYTE_W +: BYTE_W] == $past(ld_byte)));
  end
endmodule

// File: rtl/lt_ctrl_regs.sv
`timescale 1ns/1ps
module lt_ctrl_regs
  import lt_pkg::*;
#(
  parameter int TW = 16,
  localparam int NB = TW / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     lat_wr,
  input  logic              ctrl_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [TW-1:0]     latch,
  output logic [BYTE_W-1:0] ctrl
);
  logic [TW-1:0]     lat_q, lat_d;
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    lat_d  = lat_q;
    ctrl_d = ctrl_q;
    for (int i = 0; i < NB; i++) begin
      if (lat_wr[i]) lat_d[i*BYTE_W +: BYTE_W] = wdata;
    end
    if (ctrl_wr) ctrl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '1;
      ctrl_q <= '0;
    end else begin
      lat_q  <= lat_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign latch = lat_q;
  assign ctrl  = ctrl_q;

  for (genvar i = 0; i < NB; i++) begin : g_latchk
    // R6
    lat_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lat_wr[i] |=> $stable(lat_q[i*BYTE_W +: BYTE_W]));
  end
endmodule

// File: rtl/lt_readmux.sv
`timescale 1ns/1ps
module lt_readmux
  import lt_pkg::*;
#(
  parameter int TW = 16,
  localparam int NB = TW / BYTE_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TW-1:0]     cnt,
  input  logic [TW-1:0]     latch,
  input  logic [TW-1:0]     t2_cnt,
  input  logic [BYTE_W-1:0] ctrl,
  output logic [BYTE_W-1:0] rd_byte
);
  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NB; i++) begin
      if (addr == ADDR_W'(int'(A_CNT_LO) + i)) rd_byte = cnt[i*BYTE_W +: BYTE_W];
      if (addr == ADDR_W'(int'(A_LAT_LO) + i)) rd_byte = latch[i*BYTE_W +: BYTE_W];
      if (addr == ADDR_W'(int'(A_T2_LO) + i))  rd_byte = t2_cnt[i*BYTE_W +: BYTE_W];
    end
    if (addr == A_CTRL) rd_byte = ctrl;
  end
endmodule

// File: rtl/lat_timer.sv
`timescale 1ns/1ps
module lat_timer
  import lt_pkg::*;
#(
  parameter int TW     = 16,
  parameter bit HAS_T2 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              t1_set,
  output logic              t1_flag
);
  localparam int NB = TW / BYTE_W;

  logic              rst_i_n;
  logic [NB-1:0]     cnt_wr, lat_wr, t2_wr;
  logic              ctrl_wr, cnt_rd;
  logic [TW-1:0]     t1_cnt, t2_cnt, latch;
  logic [BYTE_W-1:0] ctrl, rd_byte;
  logic              t1_expire, cont_mode;
  logic              set_q, set_d, flag_q, flag_d;
  logic [BYTE_W-1:0] rdata_q, rdata_d;

  lt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  lt_regdec #(.NB(NB)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .cnt_wr(cnt_wr), .lat_wr(lat_wr), .t2_wr(t2_wr),
    .ctrl_wr(ctrl_wr), .cnt_rd(cnt_rd)
  );

  lt_ctrl_regs #(.TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .lat_wr(lat_wr), .ctrl_wr(ctrl_wr),
    .wdata(bus_wdata), .latch(latch), .ctrl(ctrl)
  );

  lt_counter #(.TW(TW)) u_t1 (
    .clk(clk), .rst_n(rst_i_n), .tick(tick_en), .ld(cnt_wr),
    .ld_byte(bus_wdata), .reload_val(latch), .count(t1_cnt), .expire(t1_expire)
  );

  if (HAS_T2) begin : g_t2
    logic t2_wrap_unused;
    lt_counter #(.TW(TW)) u_t2 (
      .clk(clk), .rst_n(rst_i_n), .tick(tick_en), .ld(t2_wr),
      .ld_byte(bus_wdata), .reload_val({TW{1'b1}}), .count(t2_cnt),
      .expire(t2_wrap_unused)
    );
  end else begin : g_no_t2
    logic [NB-1:0] t2_wr_unused;
    assign t2_wr_unused = t2_wr;
    assign t2_cnt       = '0;
  end

  lt_readmux #(.TW(TW)) u_mux (
    .addr(bus_addr), .cnt(t1_cnt), .latch(latch), .t2_cnt(t2_cnt),
    .ctrl(ctrl), .rd_byte(rd_byte)
  );

  assign cont_mode = (ctrl[7:6] == MODE_CONT);

  always_comb begin
    set_d   = t1_expire && cont_mode;
    flag_d  = set_d || (flag_q && !cnt_rd);
    rdata_d = bus_rd ? rd_byte : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      set_q   <= 1'b0;
      flag_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      set_q   <= set_d;
      flag_q  <= flag_d;
      rdata_q <= rdata_d;
    end
  end

  assign t1_set    = set_q;
  assign t1_flag   = flag_q;
  assign bus_rdata = rdata_q;

  // R4
  set_raises_flag_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    t1_set |-> t1_flag);
  // R5
  set_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    t1_set |-> ($past(ctrl[7:6]) == MODE_CONT));
  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cnt_rd && !(t1_expire && cont_mode)) |=> !t1_flag);
  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bus_rd |=> $stable(bus_rdata));
  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (t1_set && !tick_en) |=> !t1_set);
endmodule

// File: tb/lat_timer_bench.sv
`timescale 1ns/1ps
module lat_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       t1_set, t1_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lat_timer u_lat_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .t1_set(t1_set), .t1_flag(t1_flag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic read16(input logic [3:0] lo, output logic [15:0] v);
    logic [7:0] a, b;
    bus_read(lo, a);
    bus_read(lo + 4'd1, b);
    v = {b, a};
  endtask

  function automatic bit hit(int k, int c, int l);
    return (k == c) || (k > c && ((k - c) % (l + 1)) == 0);
  endfunction

  function automatic int cnt_after(int n, int c, int l);
    return (n <= c) ? (c - n) : (l - ((n - c - 1) % (l + 1)));
  endfunction

  // ticks numbered from 0; each t1_set sampled one falling edge after its tick
  task automatic run_ticks(input int n, input int c, input int l, input bit cont, input string req);
    @(negedge clk); tick_en = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == n - 1) tick_en = 1'b0;
      chk(req, {15'd0, t1_set}, {15'd0, cont && hit(k, c, l)});
    end
  endtask

  task automatic plain_ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    for (int k = 0; k < n; k++) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 flag", {15'd0, t1_flag}, 16'd0);
    chk("R1 set", {15'd0, t1_set}, 16'd0);
    read16(4'd4, v); chk("R1 count", v, 16'hFFFF);
    read16(4'd6, v); chk("R1 reload", v, 16'hFFFF);
    bus_read(4'd11, d); chk("R1 ctrl", {8'd0, d}, 16'h0000);
    read16(4'd8, v); chk("R9 t2 reset", v, 16'hFFFF);

    // R1 / R3: full period from reset
    bus_write(4'd11, 8'h40);
    run_ticks(65536, 65535, 65535, 1'b1, "R1 period");
    chk("R4 flag after period", {15'd0, t1_flag}, 16'd1);

    // R3 / R4 sweep of small start and reload values
    for (int l = 0; l < 5; l++) begin
      for (int c = 0; c < 5; c++) begin
        bus_write(4'd6, 8'(l)); bus_write(4'd7, 8'h00);
        bus_write(4'd11, 8'h40);
        bus_write(4'd4, 8'(c)); bus_write(4'd5, 8'h00);
        bus_read(4'd4, d);
        chk("R8 cleared", {15'd0, t1_flag}, 16'd0);
        run_ticks(c + 3 * (l + 1) + 1, c, l, 1'b1, "R3 R4 sweep");
        chk("R4 flag", {15'd0, t1_flag}, 16'd1);
        read16(4'd4, v);
        chk("R3 count", v, 16'(cnt_after(c + 3 * (l + 1) + 1, c, l)));
      end
    end

    // R5 other mode codes: no pulse, counter still runs
    begin
      logic [7:0] modes [4] = '{8'h00, 8'h80, 8'hC0, 8'h3F};
      for (int m = 0; m < 4; m++) begin
        bus_write(4'd6, 8'd3); bus_write(4'd11, modes[m]);
        bus_write(4'd4, 8'd2); bus_write(4'd5, 8'd0);
        bus_read(4'd5, d);
        run_ticks(10, 2, 3, 1'b0, "R5 off mode");
        chk("R5 flag", {15'd0, t1_flag}, 16'd0);
        read16(4'd4, v); chk("R5 count runs", v, 16'(cnt_after(10, 2, 3)));
      end
    end

    // R5 mode change acts on the next tick
    bus_write(4'd6, 8'd1); bus_write(4'd11, 8'h00);
    bus_write(4'd4, 8'd1);
    run_ticks(2, 1, 1, 1'b0, "R5 off then");
    bus_write(4'd11, 8'h40);
    run_ticks(4, 1, 1, 1'b1, "R5 back on");

    // R2 byte merge
    bus_write(4'd4, 8'h34); bus_write(4'd5, 8'h12);
    bus_write(4'd4, 8'hAB);
    read16(4'd4, v); chk("R2 low merge", v, 16'h12AB);
    bus_write(4'd5, 8'h56);
    read16(4'd4, v); chk("R2 high merge", v, 16'h56AB);

    // R2 write wins over tick
    bus_write(4'd4, 8'h10); bus_write(4'd5, 8'h00);
    @(negedge clk); tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 4'd4; bus_wdata = 8'h05;
    @(negedge clk); tick_en = 1'b0; bus_wr = 1'b0;
    read16(4'd4, v); chk("R2 write priority", v, 16'h0005);

    // R7 read during tick returns pre-tick value
    bus_write(4'd4, 8'h10);
    @(negedge clk); tick_en = 1'b1; bus_rd = 1'b1; bus_addr = 4'd4;
    @(negedge clk); tick_en = 1'b0; bus_rd = 1'b0;
    chk("R7 live read", {8'd0, bus_rdata}, 16'h0010);
    repeat (2) @(negedge clk);
    chk("R7 rdata held", {8'd0, bus_rdata}, 16'h0010);
    read16(4'd4, v); chk("R7 count after", v, 16'h000F);

    // R8 set wins over clear on the same edge
    bus_write(4'd11, 8'h40); bus_write(4'd4, 8'h00);
    bus_read(4'd4, d);
    chk("R8 pre", {15'd0, t1_flag}, 16'd0);
    @(negedge clk); tick_en = 1'b1; bus_rd = 1'b1; bus_addr = 4'd5;
    @(negedge clk); tick_en = 1'b0; bus_rd = 1'b0;
    chk("R8 set wins", {15'd0, t1_flag}, 16'd1);
    chk("R4 pulse", {15'd0, t1_set}, 16'd1);
    @(negedge clk);
    chk("R4 pulse one cycle", {15'd0, t1_set}, 16'd0);
    bus_read(4'd4, d);
    chk("R8 clear", {15'd0, t1_flag}, 16'd0);

    // R6 reload byte writes and use at next reload
    bus_write(4'd6, 8'h05); bus_write(4'd7, 8'h00);
    bus_write(4'd4, 8'h01); bus_write(4'd5, 8'h00);
    plain_ticks(1);
    bus_write(4'd6, 8'h02);
    plain_ticks(2);
    read16(4'd4, v); chk("R6 new reload used", v, 16'h0001);
    bus_write(4'd7, 8'hAB);
    read16(4'd6, v); chk("R6 lane merge", v, 16'hAB02);

    // R9 second counter wraps
    bus_write(4'd8, 8'h02); bus_write(4'd9, 8'h00);
    read16(4'd8, v); chk("R9 t2 write", v, 16'h0002);
    plain_ticks(3);
    read16(4'd8, v); chk("R9 t2 wrap", v, 16'hFFFF);

    // R10 unmapped addresses
    bus_write(4'd4, 8'h22); bus_write(4'd5, 8'h00);
    bus_read(4'd4, d);
    foreach (d[i]) ;
    bus_write(4'd0, 8'h77); bus_write(4'd3, 8'h77);
    bus_write(4'd12, 8'h77); bus_write(4'd15, 8'h77);
    read16(4'd4, v); chk("R10 count untouched", v, 16'h0022);
    read16(4'd6, v); chk("R10 reload untouched", v, 16'hAB02);
    chk("R10 flag untouched", {15'd0, t1_flag}, 16'd0);
    bus_read(4'd0, d);  chk("R10 read 0", {8'd0, d}, 16'h0000);
    bus_read(4'd10, d); chk("R10 read 10", {8'd0, d}, 16'h0000);
    bus_read(4'd15, d); chk("R10 read 15", {8'd0, d}, 16'h0000);
    bus_read(4'd11, d); chk("R10 ctrl readback", {8'd0, d}, 16'h0040);

    done = 1'b1;
    finish_run();
  end
endmodule